// File: doc/BRIEF.md
# Interrupt and Status Register Legalizer

This block holds the machine-level interrupt pending, interrupt enable, interrupt delegation, exception delegation, trap vector and status registers of a processor hart, together with restricted supervisor windows onto the pending, enable and status state. Every write through the register port is legalized as it is stored. Only the bits a register implements take the new data. The previous-privilege field is forced to a supported mode. Bits owned by the platform are never touched by software. The vector registers drop their reserved low bits. The supervisor windows are filtered through the interrupt delegation mask.

The register port has a write strobe, a write select and write data, and a separate read select whose data is combinational. The three platform interrupt lines (machine external, supervisor external, machine timer) are sampled into the pending register on every clock. The machine software interrupt pending bit is owned by a small memory-mapped byte register that a neighbouring interconnect writes and reads.

Top module: `csr_legalizer`

## Requirements
- R1: A write to the machine pending view (select 1) changes only bit 1 (supervisor software) and bit 5 (supervisor timer); all other pending bits keep their value.
- R2: Pending bit 11 follows `hw_meip_i`, bit 9 follows `hw_seip_i` and bit 7 follows `hw_mtip_i`, one clock after the pin is sampled; register writes have no effect on them.
- R3: A write to the machine enable view (select 2) stores only bits 1, 3, 5, 7, 9 and 12 (12 is the auxiliary-unit interrupt); every other bit reads 0.
- R4: A write to the interrupt delegation register (select 3) stores only bits 1, 5, 9 and 12.
- R5: A write to the exception delegation register (select 4) stores only bits 0, 3, 8, 12, 13 and 15.
- R6: A write to the supervisor pending view (select 8) changes only bit 1, and only when bit 1 of the delegation register is set. A read of select 8 returns the pending value ANDed with the delegation register, and a read of select 9 returns the enable value ANDed with the delegation register.
- R7: A write to the supervisor enable view (select 9) changes exactly the enable bits that are set in the delegation register.
- R8: The machine vector (select 5) stores the write data with bit 1 cleared. The supervisor vector (select 6) stores it with bits 1 and 0 cleared.
- R9: The previous-privilege field (status bits 12:11; U=0, S=1, H=2, M=3) is legalized on every write and at reset. It becomes M when user mode is not supported. It becomes U for the value H, or for any value when supervisor mode is not supported. Otherwise it keeps the written value.
- R10: The machine status view (select 0) stores bits 1, 3, 5, 7, the 2-bit fields at 14:13 (FP state) and 16:15 (extension state), and bit 8 only when supervisor mode is supported. All other bits below XLEN-1 read 0.
- R11: Status bit XLEN-1 reads 1 exactly when the FP-state field or the extension-state field equals 3. It cannot be written.
- R12: The supervisor status view (select 7) reads status bits 1, 5, 8, 14:13, 16:15 and XLEN-1, and zero elsewhere. A write to it changes only bits 1, 5, 8, 14:13 and 16:15.
- R13: A byte write on the memory-mapped port at offset 0 sets pending bit 3 from data bit 0. A read at offset 0 returns that bit in bit 0 and zeros elsewhere. Any other offset ignores writes and reads 0.
- R14: After reset every register reads 0, apart from a legalized previous-privilege field. Selects 10 to 15 read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| csr_we_i | input | 1 | Register write strobe |
| csr_waddr_i | input | 4 | Register write select |
| csr_wdata_i | input | XLEN | Register write data |
| csr_raddr_i | input | 4 | Register read select |
| csr_rdata_o | output | XLEN | Register read data (combinational) |
| hw_meip_i | input | 1 | Machine external interrupt line |
| hw_seip_i | input | 1 | Supervisor external interrupt line |
| hw_mtip_i | input | 1 | Machine timer interrupt line |
| sw_irq_we_i | input | 1 | Memory-mapped byte write strobe |
| sw_irq_addr_i | input | MMIO_AW | Memory-mapped byte offset |
| sw_irq_wdata_i | input | 8 | Memory-mapped write byte |
| sw_irq_rdata_o | output | 32 | Memory-mapped read word |

## Verification
The hardest situation to reach is a supervisor-view write whose effect depends on the delegation register, combined with platform pending lines. The filtering can only be seen when delegation, enable, and the platform-owned pending bits hold mixed values at the moment of the write. The stimulus first programs delegation to a partial mask, then raises the supervisor external line, and then issues all-ones and all-zeros writes through the supervisor windows. The machine views are read back to show which bits moved. Previous-privilege legalization depends on elaboration parameters, so three instances with different mode support share one stimulus stream and are compared side by side.

// File: rtl/csr_lgz_pkg.sv
package csr_lgz_pkg;

  localparam int unsigned SEL_W = 4;

  localparam logic [SEL_W-1:0] SEL_M_STAT  = 4'd0;
  localparam logic [SEL_W-1:0] SEL_M_PEND  = 4'd1;
  localparam logic [SEL_W-1:0] SEL_M_EN    = 4'd2;
  localparam logic [SEL_W-1:0] SEL_IRQ_DLG = 4'd3;
  localparam logic [SEL_W-1:0] SEL_EXC_DLG = 4'd4;
  localparam logic [SEL_W-1:0] SEL_M_VEC   = 4'd5;
  localparam logic [SEL_W-1:0] SEL_S_VEC   = 4'd6;
  localparam logic [SEL_W-1:0] SEL_S_STAT  = 4'd7;
  localparam logic [SEL_W-1:0] SEL_S_PEND  = 4'd8;
  localparam logic [SEL_W-1:0] SEL_S_EN    = 4'd9;

  // interrupt bit positions
  localparam int unsigned IRQ_S_SW  = 1;
  localparam int unsigned IRQ_M_SW  = 3;
  localparam int unsigned IRQ_S_TMR = 5;
  localparam int unsigned IRQ_M_TMR = 7;
  localparam int unsigned IRQ_S_EXT = 9;
  localparam int unsigned IRQ_M_EXT = 11;
  localparam int unsigned IRQ_AUX   = 12;

  localparam logic [15:0] PEND_SW_MASK = 16'h0022;
  localparam logic [15:0] DLG_MASK     = 16'h1222;
  localparam logic [15:0] EN_MASK      = 16'h12AA;
  localparam logic [15:0] EXC_MASK     = 16'hB109;

  // status field positions
  localparam int unsigned ST_S_IE   = 1;
  localparam int unsigned ST_M_IE   = 3;
  localparam int unsigned ST_S_PIE  = 5;
  localparam int unsigned ST_M_PIE  = 7;
  localparam int unsigned ST_S_PP   = 8;
  localparam int unsigned ST_M_PP   = 11;
  localparam int unsigned ST_FP     = 13;
  localparam int unsigned ST_XT     = 15;

  localparam logic [16:0] ST_BASE_WMASK = 17'h1E0AA;
  localparam logic [16:0] ST_S_VIEW     = 17'h1E122;

  localparam logic [1:0] PRV_U = 2'd0;
  localparam logic [1:0] PRV_S = 2'd1;
  localparam logic [1:0] PRV_H = 2'd2;
  localparam logic [1:0] PRV_M = 2'd3;

endpackage

// File: rtl/csr_lgz_irq.sv
module csr_lgz_irq
  import csr_lgz_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned MMIO_AW = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               csr_we_i,
  input  logic [SEL_W-1:0]   csr_waddr_i,
  input  logic [XLEN-1:0]    csr_wdata_i,
  input  logic               hw_meip_i,
  input  logic               hw_seip_i,
  input  logic               hw_mtip_i,
  input  logic               sw_irq_we_i,
  input  logic [MMIO_AW-1:0] sw_irq_addr_i,
  input  logic [7:0]         sw_irq_wdata_i,
  output logic [XLEN-1:0]    m_pend_o,
  output logic [XLEN-1:0]    m_en_o,
  output logic [XLEN-1:0]    irq_dlg_o
);

  localparam logic [XLEN-1:0] EN_M  = XLEN'(EN_MASK);
  localparam logic [XLEN-1:0] DLG_M = XLEN'(DLG_MASK);

  logic we_m_pend, we_s_pend, we_m_en, we_s_en, we_dlg, sw_hit;
  logic [XLEN-1:0] en_q, dlg_q;

  assign we_m_pend = csr_we_i && (csr_waddr_i == SEL_M_PEND);
  assign we_s_pend = csr_we_i && (csr_waddr_i == SEL_S_PEND);
  assign we_m_en   = csr_we_i && (csr_waddr_i == SEL_M_EN);
  assign we_s_en   = csr_we_i && (csr_waddr_i == SEL_S_EN);
  assign we_dlg    = csr_we_i && (csr_waddr_i == SEL_IRQ_DLG);
  assign sw_hit    = sw_irq_we_i && (sw_irq_addr_i == '0);

  // per-bit pending storage, variant picked by bit owner
  for (genvar i = 0; i < XLEN; i++) begin : g_pend
    if (i == IRQ_M_EXT || i == IRQ_S_EXT || i == IRQ_M_TMR) begin : g_hw
      logic pin, q;
      if (i == IRQ_M_EXT) begin : g_me
        assign pin = hw_meip_i;
      end else if (i == IRQ_S_EXT) begin : g_se
        assign pin = hw_seip_i;
      end else begin : g_mt
        assign pin = hw_mtip_i;
      end
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) q <= 1'b0;
        else         q <= pin;
      assign m_pend_o[i] = q;
    end else if (i == IRQ_M_SW) begin : g_mmio
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni)     q <= 1'b0;
        else if (sw_hit) q <= sw_irq_wdata_i[0];
      assign m_pend_o[i] = q;
    end else if (i == IRQ_S_SW || i == IRQ_S_TMR) begin : g_sw
      logic q, s_ok;
      assign s_ok = (i == IRQ_S_SW) && dlg_q[i];
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni)                    q <= 1'b0;
        else if (we_m_pend)             q <= csr_wdata_i[i];
        else if (we_s_pend && s_ok)     q <= csr_wdata_i[i];
      assign m_pend_o[i] = q;
    end else begin : g_none
      assign m_pend_o[i] = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      dlg_q <= '0;
    end else begin
      if (we_m_en)      en_q <= (en_q & ~EN_M) | (csr_wdata_i & EN_M);
      else if (we_s_en) en_q <= (en_q & ~dlg_q) | (csr_wdata_i & dlg_q);
      if (we_dlg)       dlg_q <= csr_wdata_i & DLG_M;
    end
  end

  assign m_en_o    = en_q;
  assign irq_dlg_o = dlg_q;

endmodule

// File: rtl/csr_lgz_trap.sv
module csr_lgz_trap
  import csr_lgz_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             csr_we_i,
  input  logic [SEL_W-1:0] csr_waddr_i,
  input  logic [XLEN-1:0]  csr_wdata_i,
  output logic [XLEN-1:0]  exc_dlg_o,
  output logic [XLEN-1:0]  m_vec_o,
  output logic [XLEN-1:0]  s_vec_o
);

  localparam logic [XLEN-1:0] EXC_M   = XLEN'(EXC_MASK);
  localparam logic [XLEN-1:0] M_VEC_M = ~XLEN'(2);
  localparam logic [XLEN-1:0] S_VEC_M = ~XLEN'(3);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exc_dlg_o <= '0;
      m_vec_o   <= '0;
      s_vec_o   <= '0;
    end else if (csr_we_i) begin
      case (csr_waddr_i)
        SEL_EXC_DLG: exc_dlg_o <= csr_wdata_i & EXC_M;
        SEL_M_VEC:   m_vec_o   <= csr_wdata_i & M_VEC_M;
        SEL_S_VEC:   s_vec_o   <= csr_wdata_i & S_VEC_M;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/csr_lgz_status.sv
module csr_lgz_status
  import csr_lgz_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter bit          HAS_S = 1'b1,
  parameter bit          HAS_U = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             csr_we_i,
  input  logic [SEL_W-1:0] csr_waddr_i,
  input  logic [XLEN-1:0]  csr_wdata_i,
  output logic [XLEN-1:0]  m_stat_o
);

  localparam logic [XLEN-1:0] SPP_BIT = XLEN'(1) << ST_S_PP;
  localparam logic [XLEN-1:0] WMASK   = XLEN'(ST_BASE_WMASK) | (HAS_S ? SPP_BIT : '0);
  localparam logic [XLEN-1:0] SMASK   = XLEN'(ST_S_VIEW) & WMASK;

  function automatic logic [1:0] legal_pp(input logic [1:0] v);
    if (!HAS_U)                   return PRV_M;
    else if (v == PRV_H || !HAS_S) return PRV_U;
    else                          return v;
  endfunction

  logic [XLEN-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q <= XLEN'(legal_pp(PRV_U)) << ST_M_PP;
    end else if (csr_we_i && csr_waddr_i == SEL_M_STAT) begin
      q <= (csr_wdata_i & WMASK) |
           (XLEN'(legal_pp(csr_wdata_i[ST_M_PP +: 2])) << ST_M_PP);
    end else if (csr_we_i && csr_waddr_i == SEL_S_STAT) begin
      q <= (q & ~SMASK) | (csr_wdata_i & SMASK);
    end
  end

  assign m_stat_o = q;

endmodule

// File: rtl/csr_legalizer.sv
module csr_legalizer
  import csr_lgz_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned MMIO_AW = 4,
  parameter bit          HAS_S   = 1'b1,
  parameter bit          HAS_U   = 1'b1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               csr_we_i,
  input  logic [3:0]         csr_waddr_i,
  input  logic [XLEN-1:0]    csr_wdata_i,
  input  logic [3:0]         csr_raddr_i,
  output logic [XLEN-1:0]    csr_rdata_o,
  input  logic               hw_meip_i,
  input  logic               hw_seip_i,
  input  logic               hw_mtip_i,
  input  logic               sw_irq_we_i,
  input  logic [MMIO_AW-1:0] sw_irq_addr_i,
  input  logic [7:0]         sw_irq_wdata_i,
  output logic [31:0]        sw_irq_rdata_o
);

  localparam logic [XLEN-1:0] S_VIEW = XLEN'(ST_S_VIEW);

  logic [XLEN-1:0] m_pend_q, m_en_q, irq_dlg_q, exc_dlg_q, m_vec_q, s_vec_q, m_stat_q;
  logic            dirty;

  csr_lgz_irq #(.XLEN(XLEN), .MMIO_AW(MMIO_AW)) i_irq (
    .clk_i, .rst_ni, .csr_we_i, .csr_waddr_i, .csr_wdata_i,
    .hw_meip_i, .hw_seip_i, .hw_mtip_i,
    .sw_irq_we_i, .sw_irq_addr_i, .sw_irq_wdata_i,
    .m_pend_o (m_pend_q),
    .m_en_o   (m_en_q),
    .irq_dlg_o(irq_dlg_q)
  );

  csr_lgz_trap #(.XLEN(XLEN)) i_trap (
    .clk_i, .rst_ni, .csr_we_i, .csr_waddr_i, .csr_wdata_i,
    .exc_dlg_o(exc_dlg_q),
    .m_vec_o  (m_vec_q),
    .s_vec_o  (s_vec_q)
  );

  csr_lgz_status #(.XLEN(XLEN), .HAS_S(HAS_S), .HAS_U(HAS_U)) i_status (
    .clk_i, .rst_ni, .csr_we_i, .csr_waddr_i, .csr_wdata_i,
    .m_stat_o(m_stat_q)
  );

  assign dirty = (m_stat_q[ST_FP +: 2] == 2'b11) || (m_stat_q[ST_XT +: 2] == 2'b11);

  always_comb begin
    case (csr_raddr_i)
      SEL_M_STAT:  csr_rdata_o = {dirty, m_stat_q[XLEN-2:0]};
      SEL_M_PEND:  csr_rdata_o = m_pend_q;
      SEL_M_EN:    csr_rdata_o = m_en_q;
      SEL_IRQ_DLG: csr_rdata_o = irq_dlg_q;
      SEL_EXC_DLG: csr_rdata_o = exc_dlg_q;
      SEL_M_VEC:   csr_rdata_o = m_vec_q;
      SEL_S_VEC:   csr_rdata_o = s_vec_q;
      SEL_S_STAT:  csr_rdata_o = {dirty, m_stat_q[XLEN-2:0] & S_VIEW[XLEN-2:0]};
      SEL_S_PEND:  csr_rdata_o = m_pend_q & irq_dlg_q;
      SEL_S_EN:    csr_rdata_o = m_en_q & irq_dlg_q;
      default:     csr_rdata_o = '0;
    endcase
  end

  assign sw_irq_rdata_o = (sw_irq_addr_i == '0) ? {31'b0, m_pend_q[IRQ_M_SW]} : 32'b0;

endmodule

// File: rtl/csr_legalizer_chk.sv
module csr_legalizer_chk
  import csr_lgz_pkg::*;
#(
  parameter int unsigned XLEN    = 32,
  parameter int unsigned MMIO_AW = 4,
  parameter bit          HAS_U   = 1'b1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               csr_we_i,
  input logic [3:0]         csr_waddr_i,
  input logic [XLEN-1:0]    csr_wdata_i,
  input logic [3:0]         csr_raddr_i,
  input logic [XLEN-1:0]    csr_rdata_o,
  input logic               hw_meip_i,
  input logic               hw_seip_i,
  input logic               hw_mtip_i,
  input logic               sw_irq_we_i,
  input logic [MMIO_AW-1:0] sw_irq_addr_i,
  input logic [7:0]         sw_irq_wdata_i,
  input logic [XLEN-1:0]    m_pend_q,
  input logic [XLEN-1:0]    irq_dlg_q,
  input logic [XLEN-1:0]    m_vec_q,
  input logic [XLEN-1:0]    m_stat_q
);

  p_hw_pend_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (m_pend_q[IRQ_M_EXT] == $past(hw_meip_i)) &&
             (m_pend_q[IRQ_S_EXT] == $past(hw_seip_i)) &&
             (m_pend_q[IRQ_M_TMR] == $past(hw_mtip_i)));

  p_dlg_mask_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && csr_waddr_i == SEL_IRQ_DLG) |=>
      irq_dlg_q == ($past(csr_wdata_i) & XLEN'(DLG_MASK)));

  p_s_pend_read_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_raddr_i == SEL_S_PEND) |-> csr_rdata_o == (m_pend_q & irq_dlg_q));

  p_m_vec_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_we_i && csr_waddr_i == SEL_M_VEC) |=>
      m_vec_q == ($past(csr_wdata_i) & ~XLEN'(2)));

  p_pp_not_h_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_stat_q[ST_M_PP +: 2] != PRV_H);

  p_pp_no_u_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    HAS_U || (m_stat_q[ST_M_PP +: 2] == PRV_M));

  p_dirty_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_raddr_i == SEL_M_STAT) |->
      csr_rdata_o[XLEN-1] == ((m_stat_q[ST_FP +: 2] == 2'b11) || (m_stat_q[ST_XT +: 2] == 2'b11)));

  p_mmio_sw_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_irq_we_i && sw_irq_addr_i == '0) |=> m_pend_q[IRQ_M_SW] == $past(sw_irq_wdata_i[0]));

  p_mmio_hold_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sw_irq_we_i && sw_irq_addr_i == '0) |=> $stable(m_pend_q[IRQ_M_SW]));

endmodule

bind csr_legalizer csr_legalizer_chk #(.XLEN(XLEN), .MMIO_AW(MMIO_AW), .HAS_U(HAS_U)) i_chk (.*);

// File: tb/test_csr_legalizer.sv
`timescale 1ns/1ps
module test_csr_legalizer;

  localparam int XLEN = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  waddr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  raddr = '0;
  logic        meip = 1'b0, seip = 1'b0, mtip = 1'b0;
  logic        swe = 1'b0;
  logic [3:0]  saddr = '0;
  logic [7:0]  swdata = '0;
  logic [31:0] rd_a, rd_b, rd_c, srd_a, srd_b, srd_c;

  int checks = 0;
  int errors = 0;
  logic [31:0] v;

  always #4 clk = ~clk;

  csr_legalizer #(.XLEN(XLEN)) i_csr_legalizer (
    .clk_i(clk), .rst_ni(rst_n), .csr_we_i(we), .csr_waddr_i(waddr), .csr_wdata_i(wdata),
    .csr_raddr_i(raddr), .csr_rdata_o(rd_a), .hw_meip_i(meip), .hw_seip_i(seip),
    .hw_mtip_i(mtip), .sw_irq_we_i(swe), .sw_irq_addr_i(saddr),
    .sw_irq_wdata_i(swdata), .sw_irq_rdata_o(srd_a));

  csr_legalizer #(.XLEN(XLEN), .HAS_U(1'b0)) i_csr_legalizer_nou (
    .clk_i(clk), .rst_ni(rst_n), .csr_we_i(we), .csr_waddr_i(waddr), .csr_wdata_i(wdata),
    .csr_raddr_i(raddr), .csr_rdata_o(rd_b), .hw_meip_i(meip), .hw_seip_i(seip),
    .hw_mtip_i(mtip), .sw_irq_we_i(swe), .sw_irq_addr_i(saddr),
    .sw_irq_wdata_i(swdata), .sw_irq_rdata_o(srd_b));

  csr_legalizer #(.XLEN(XLEN), .HAS_S(1'b0)) i_csr_legalizer_nos (
    .clk_i(clk), .rst_ni(rst_n), .csr_we_i(we), .csr_waddr_i(waddr), .csr_wdata_i(wdata),
    .csr_raddr_i(raddr), .csr_rdata_o(rd_c), .hw_meip_i(meip), .hw_seip_i(seip),
    .hw_mtip_i(mtip), .sw_irq_we_i(swe), .sw_irq_addr_i(saddr),
    .sw_irq_wdata_i(swdata), .sw_irq_rdata_o(srd_c));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; waddr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a);
    raddr = a;
    #1;
  endtask

  task automatic swr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    swe = 1'b1; saddr = a; swdata = d;
    @(negedge clk);
    swe = 1'b0;
  endtask

  function automatic logic [1:0] pp_full(input logic [1:0] x);
    return (x == 2'd2) ? 2'd0 : x;
  endfunction

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R14 reset state
    for (int s = 0; s < 16; s++) begin
      rd(4'(s));
      chk("R14 reset main", rd_a, 32'h0);
      chk("R14 reset no-S", rd_c, 32'h0);
    end
    rd(4'd0);
    chk("R9 reset no-U pp=M", rd_b, 32'h0000_1800);

    // R1 pending sweep
    for (int b = 0; b < 32; b++) begin
      wr(4'd1, 32'h1 << b); rd(4'd1);
      chk("R1 pending mask", rd_a, (32'h1 << b) & 32'h22);
    end
    wr(4'd1, 32'hFFFF_FFFF); rd(4'd1);
    chk("R1 pending all-ones", rd_a, 32'h22);

    // R3 enable sweep
    for (int b = 0; b < 32; b++) begin
      wr(4'd2, 32'h1 << b); rd(4'd2);
      chk("R3 enable mask", rd_a, (32'h1 << b) & 32'h12AA);
    end
    // R4 delegation sweep
    for (int b = 0; b < 32; b++) begin
      wr(4'd3, 32'h1 << b); rd(4'd3);
      chk("R4 irq deleg mask", rd_a, (32'h1 << b) & 32'h1222);
    end
    // R5 exception delegation sweep
    for (int b = 0; b < 32; b++) begin
      wr(4'd4, 32'h1 << b); rd(4'd4);
      chk("R5 exc deleg mask", rd_a, (32'h1 << b) & 32'hB109);
    end

    // R8 vectors
    for (int k = 0; k < 4; k++) begin
      v = (k == 0) ? 32'hFFFF_FFFF : (k == 1) ? 32'h1234_5677 : (k == 2) ? 32'hA5A5_A5A6 : 32'h0000_0001;
      wr(4'd5, v); rd(4'd5);
      chk("R8 machine vector", rd_a, v & ~32'h2);
      wr(4'd6, v); rd(4'd6);
      chk("R8 supervisor vector", rd_a, v & ~32'h3);
    end

    // R10 status sweep, bits 11/12 drive pp legalization (R9)
    for (int b = 0; b < 32; b++) begin
      wr(4'd0, 32'h1 << b); rd(4'd0);
      if (b == 11)      v = 32'h800;
      else if (b == 12) v = 32'h0;
      else              v = (32'h1 << b) & 32'h1E1AA;
      chk("R10 status mask", rd_a, v);
      chk("R10 status no-S spp", rd_c, (32'h1 << b) & 32'h1E0AA);
    end

    // R9 pp legalization across configurations
    for (int p = 0; p < 4; p++) begin
      wr(4'd0, 32'(p) << 11); rd(4'd0);
      chk("R9 pp full modes", rd_a, 32'(pp_full(2'(p))) << 11);
      chk("R9 pp no-U", rd_b, 32'h1800);
      chk("R9 pp no-S", rd_c, 32'h0);
    end

    // R11 dirty summary
    wr(4'd0, 32'h0000_6000); rd(4'd0);
    chk("R11 fp dirty", rd_a, 32'h8000_6000);
    wr(4'd0, 32'h0001_8000); rd(4'd0);
    chk("R11 ext dirty", rd_a, 32'h8001_8000);
    wr(4'd0, 32'h8000_4000); rd(4'd0);
    chk("R11 not dirty", rd_a, 32'h0000_4000);

    // R12 supervisor status view
    wr(4'd0, 32'h0001_F9AA); rd(4'd7);
    chk("R12 s-status read", rd_a, 32'h8001_E122);
    wr(4'd7, 32'h0); rd(4'd0);
    chk("R12 s-status clear", rd_a, 32'h0000_1888);
    wr(4'd7, 32'hFFFF_FFFF); rd(4'd0);
    chk("R12 s-status set", rd_a, 32'h8001_F9AA);

    // R6/R7 supervisor pending and enable with partial delegation
    wr(4'd1, 32'h0); wr(4'd2, 32'h0); wr(4'd3, 32'h0);
    wr(4'd8, 32'hFFFF_FFFF); rd(4'd1);
    chk("R6 s-pend undelegated", rd_a, 32'h0);
    wr(4'd3, 32'h0000_0222);
    @(negedge clk); seip = 1'b1; @(negedge clk);
    wr(4'd8, 32'hFFFF_FFFF); rd(4'd1);
    chk("R6 s-pend delegated", rd_a, 32'h0000_0202);
    rd(4'd8);
    chk("R6 s-pend read", rd_a, 32'h0000_0202);
    wr(4'd9, 32'hFFFF_FFFF); rd(4'd2);
    chk("R7 s-enable set", rd_a, 32'h0000_0222);
    wr(4'd2, 32'h12AA); wr(4'd9, 32'h0); rd(4'd2);
    chk("R7 s-enable clear", rd_a, 32'h0000_1088);
    rd(4'd9);
    chk("R6 s-enable read", rd_a, 32'h0);
    wr(4'd2, 32'h12AA); rd(4'd9);
    chk("R6 s-enable filtered", rd_a, 32'h0000_0222);

    // R2 platform pending lines
    @(negedge clk); meip = 1'b1; mtip = 1'b1; seip = 1'b1; rd(4'd1);
    chk("R2 before edge", rd_a, 32'h0000_0202);
    @(negedge clk); rd(4'd1);
    chk("R2 lines sampled", rd_a, 32'h0000_0A82);
    wr(4'd1, 32'h0); rd(4'd1);
    chk("R2 write keeps lines", rd_a, 32'h0000_0A80);
    @(negedge clk); meip = 1'b0; mtip = 1'b0; seip = 1'b0;
    @(negedge clk); rd(4'd1);
    chk("R2 lines dropped", rd_a, 32'h0);

    // R13 memory-mapped software pending
    swr(4'd0, 8'hFF); rd(4'd1); saddr = 4'd0; #1;
    chk("R13 set pending", rd_a, 32'h0000_0008);
    chk("R13 mmio read", srd_a, 32'h1);
    swr(4'd4, 8'h00); rd(4'd1);
    chk("R13 other offset ignored", rd_a, 32'h0000_0008);
    saddr = 4'd4; #1;
    chk("R13 other offset reads 0", srd_a, 32'h0);
    wr(4'd1, 32'h0); rd(4'd1);
    chk("R1 write keeps mmio bit", rd_a, 32'h0000_0008);
    swr(4'd0, 8'hFE); rd(4'd1); saddr = 4'd0; #1;
    chk("R13 clear pending", rd_a, 32'h0);
    chk("R13 mmio read clear", srd_a, 32'h0);

    // R14 undefined selects
    wr(4'd3, 32'h0000_1222);
    for (int s = 10; s < 16; s++) begin
      wr(4'(s), 32'hFFFF_FFFF); rd(4'(s));
      chk("R14 undefined read", rd_a, 32'h0);
    end
    rd(4'd3);
    chk("R14 undefined write no effect", rd_a, 32'h0000_1222);
    rd(4'd2);
    chk("R14 enable untouched", rd_a, 32'h0000_12AA);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule